// File: doc/BRIEF.md
# Program Memory Region Decoder with Wait-State Control

This block sits between the program fetch port of an 8-bit processor core and three program stores. It sorts each 24-bit program address into one of three regions: a small on-chip boot ROM at the bottom of the map, a 4 KB on-chip RAM window just below the 64 KB line, and an off-chip memory that takes every other address. For the selected region it drives the local address, steers that region's 8-bit read data back to the core, and produces the ready signal for the core.

The two on-chip regions finish every access in the cycle it is issued. An off-chip access holds ready low for a number of wait cycles set by a 3-bit configuration input. An external ready input can hold it low for longer, so a slow device or a dynamic memory controller can extend the cycle. The RAM window can be written through the program-write strobe, which lets boot code copy time-critical routines into it. Writes that decode to the ROM go to no memory and have no effect.

The core must keep address, strobes and write data stable while ready is low. Once an off-chip access has started, the block keeps treating it as off-chip until it completes, so any other access waits until ready returns.

Top module: `prog_mem_decoder`

## Requirements
- R1: Addresses 0x000000 to 0x0003FF select the ROM. `rom_addr_o` carries address bits [9:0], `cpu_rdata_o` returns `rom_rdata_i`, and `cpu_ready_o` is high in the cycle the access is issued.
- R2: Addresses 0x00F000 to 0x00FFFF select the RAM. `ram_addr_o` carries the 12-bit offset from 0x00F000, `cpu_rdata_o` returns `ram_rdata_i`, and `cpu_ready_o` is high in the cycle the access is issued.
- R3: Addresses 0x000400 to 0x00EFFF and 0x010000 to 0xFFFFFF select off-chip memory. `ext_addr_o` carries all 24 address bits, and `cpu_rdata_o` returns `ext_rdata_i` in the completing cycle.
- R4: With `ext_ready_i` high, an off-chip access holds `cpu_ready_o` low for exactly `ws_cfg_i` cycles, counted from its first cycle, and raises it in the next cycle. Any setting from 0 to 7 works.
- R5: While `ext_ready_i` is low, an off-chip access does not complete. If `ext_ready_i` is low for the first K cycles, the access takes max(`ws_cfg_i`, K) wait cycles.
- R6: A write to the RAM window raises `ram_we_o` with `ram_wdata_o` = `cpu_wdata_i`, and `cpu_ready_o` is high in the same cycle. The written byte reads back afterwards.
- R7: A write to the ROM region completes at once with no strobe on `ram_we_o` or `ext_wr_o`. It changes no stored byte, including the RAM byte at the same local offset.
- R8: An off-chip write drives `ext_wr_o`, `ext_wdata_o` and the full address, and follows the same wait-state timing as an off-chip read.
- R9: While `rst_ni` is low, `ext_rd_o` and `ext_wr_o` are low. Reset clears the wait counter, so the first off-chip access after reset waits the full `ws_cfg_i` cycles even if reset cut a pending access short.
- R10: With neither `cpu_rd_i` nor `cpu_wr_i` asserted, `cpu_ready_o` is high and `ext_rd_o`, `ext_wr_o` and `ram_we_o` are all low.
- R11: The off-chip read and write strobes are never asserted together with `ram_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 24 | Program address from the core |
| cpu_rd_i | input | 1 | Program read request |
| cpu_wr_i | input | 1 | Program write request |
| cpu_wdata_i | input | 8 | Program write data |
| cpu_rdata_o | output | 8 | Read data steered from the selected region |
| cpu_ready_o | output | 1 | Access completes in this cycle |
| ws_cfg_i | input | 3 | Off-chip wait-state count |
| rom_addr_o | output | 10 | ROM local address |
| rom_rdata_i | input | 8 | ROM read data |
| ram_addr_o | output | 12 | RAM local address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_rdata_i | input | 8 | RAM read data |
| ext_addr_o | output | 24 | Off-chip address |
| ext_wdata_o | output | 8 | Off-chip write data |
| ext_rd_o | output | 1 | Off-chip read strobe |
| ext_wr_o | output | 1 | Off-chip write strobe |
| ext_rdata_i | input | 8 | Off-chip read data |
| ext_ready_i | input | 1 | Off-chip ready, may stretch the cycle |

## Verification
The assertions check on every cycle that on-chip reads and RAM writes complete at once, that an idle port is ready with no strobes, that RAM and off-chip write strobes never overlap, and that the strobes stay low during reset. An independent counter in the checker also confirms that an off-chip access never completes before `ws_cfg_i` cycles and never stalls past that point while `ext_ready_i` is high. Only the bench's scenarios can show that the correct byte comes back from each region, that the edge addresses decode correctly, that written RAM data reads back, that a ROM write leaves the aliased RAM byte unchanged, and that a reset during a pending access restarts the count.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_EXT  = 2'd3
  } rgn_e;
endpackage

// File: rtl/pmd_region_decode.sv
module pmd_region_decode
  import pmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned ROM_AW   = 10,
  parameter int unsigned RAM_AW   = 12,
  parameter int unsigned RAM_BASE = 32'h0000_F000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o
);
  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(64'd1 << ROM_AW);
  localparam logic [ADDR_W-1:0] RAM_LO  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI  = ADDR_W'(64'(RAM_BASE) + (64'd1 << RAM_AW));

  logic in_rom, in_ram;

  assign in_rom = (addr_i < ROM_END);
  assign in_ram = (addr_i >= RAM_LO) && (addr_i < RAM_HI);

  always_comb begin
    if (in_rom)      rgn_o = RGN_ROM;
    else if (in_ram) rgn_o = RGN_RAM;
    else             rgn_o = RGN_EXT;
  end
endmodule

// File: rtl/pmd_wait_ctrl.sv
module pmd_wait_ctrl
  import pmd_pkg::*;
#(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  rgn_e            rgn_dec_i,
  input  logic [WS_W-1:0] ws_cfg_i,
  input  logic            ext_ready_i,
  output rgn_e            rgn_o,
  output logic            ext_act_o,
  output logic            ext_done_o
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;
  logic            cnt_hit;

  // a started off-chip access keeps the off-chip region until it completes
  assign rgn_o      = busy_q ? RGN_EXT : rgn_dec_i;
  assign ext_act_o  = acc_i && (rgn_o == RGN_EXT);
  assign cnt_hit    = (cnt_q >= ws_cfg_i);
  assign ext_done_o = ext_act_o && cnt_hit && ext_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ext_act_o && !ext_done_o) begin
      busy_q <= 1'b1;
      if (!cnt_hit) cnt_q <= cnt_q + 1'b1;
    end else begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/pmd_data_path.sv
module pmd_data_path
  import pmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ROM_AW   = 10,
  parameter int unsigned RAM_AW   = 12,
  parameter int unsigned RAM_BASE = 32'h0000_F000
) (
  input  logic              rst_ni,
  input  rgn_e              rgn_i,
  input  logic              ext_act_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);

  logic [ADDR_W-1:0] ram_off;

  assign ram_off    = addr_i - RAM_LO;
  assign rom_addr_o = addr_i[ROM_AW-1:0];
  assign ram_addr_o = ram_off[RAM_AW-1:0];
  assign ext_addr_o = addr_i;

  assign ram_wdata_o = wdata_i;
  assign ext_wdata_o = wdata_i;

  assign ram_we_o = rst_ni && wr_i && !rd_i && (rgn_i == RGN_RAM);
  assign ext_rd_o = rst_ni && ext_act_i && rd_i;
  assign ext_wr_o = rst_ni && ext_act_i && wr_i && !rd_i;

  always_comb begin
    unique case (rgn_i)
      RGN_ROM: rdata_o = rom_rdata_i;
      RGN_RAM: rdata_o = ram_rdata_i;
      RGN_EXT: rdata_o = ext_rdata_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prog_mem_decoder.sv
module prog_mem_decoder
  import pmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ROM_AW   = 10,
  parameter int unsigned RAM_AW   = 12,
  parameter int unsigned RAM_BASE = 32'h0000_F000,
  parameter int unsigned WS_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  input  logic [WS_W-1:0]   ws_cfg_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  input  logic              ext_ready_i
);
  rgn_e rgn_dec, rgn;
  logic acc, ext_act, ext_done;

  assign acc = cpu_rd_i || cpu_wr_i;

  pmd_region_decode #(
    .ADDR_W  (ADDR_W),
    .ROM_AW  (ROM_AW),
    .RAM_AW  (RAM_AW),
    .RAM_BASE(RAM_BASE)
  ) u_dec (
    .addr_i(cpu_addr_i),
    .rgn_o (rgn_dec)
  );

  pmd_wait_ctrl #(
    .WS_W(WS_W)
  ) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .rgn_dec_i  (rgn_dec),
    .ws_cfg_i   (ws_cfg_i),
    .ext_ready_i(ext_ready_i),
    .rgn_o      (rgn),
    .ext_act_o  (ext_act),
    .ext_done_o (ext_done)
  );

  pmd_data_path #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ROM_AW  (ROM_AW),
    .RAM_AW  (RAM_AW),
    .RAM_BASE(RAM_BASE)
  ) u_dp (
    .rst_ni     (rst_ni),
    .rgn_i      (rgn),
    .ext_act_i  (ext_act),
    .addr_i     (cpu_addr_i),
    .rd_i       (cpu_rd_i),
    .wr_i       (cpu_wr_i),
    .wdata_i    (cpu_wdata_i),
    .rdata_o    (cpu_rdata_o),
    .rom_addr_o (rom_addr_o),
    .rom_rdata_i(rom_rdata_i),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .ram_we_o   (ram_we_o),
    .ram_rdata_i(ram_rdata_i),
    .ext_addr_o (ext_addr_o),
    .ext_wdata_o(ext_wdata_o),
    .ext_rd_o   (ext_rd_o),
    .ext_wr_o   (ext_wr_o),
    .ext_rdata_i(ext_rdata_i)
  );

  // on-chip regions and idle cycles never stall
  assign cpu_ready_o = !ext_act || ext_done;
endmodule

// File: rtl/prog_mem_decoder_chk.sv
module prog_mem_decoder_chk #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned ROM_AW   = 10,
  parameter int unsigned RAM_AW   = 12,
  parameter int unsigned RAM_BASE = 32'h0000_F000,
  parameter int unsigned WS_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_rd_i,
  input logic              cpu_wr_i,
  input logic              cpu_ready_o,
  input logic [WS_W-1:0]   ws_cfg_i,
  input logic              ram_we_o,
  input logic              ext_rd_o,
  input logic              ext_wr_o,
  input logic              ext_ready_i
);
  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(64'd1 << ROM_AW);
  localparam logic [ADDR_W-1:0] RAM_LO  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI  = ADDR_W'(64'(RAM_BASE) + (64'd1 << RAM_AW));

  logic ext_any, acc;
  logic [WS_W:0] wait_cnt_q;

  assign ext_any = ext_rd_o || ext_wr_o;
  assign acc     = cpu_rd_i || cpu_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wait_cnt_q <= '0;
    else if (ext_any && !cpu_ready_o) begin
      if (wait_cnt_q != '1) wait_cnt_q <= wait_cnt_q + 1'b1;
    end else                         wait_cnt_q <= '0;
  end

  // R1
  rom_zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cpu_addr_i < ROM_END && !ext_any) |-> cpu_ready_o);

  // R2
  ram_zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && cpu_addr_i >= RAM_LO && cpu_addr_i < RAM_HI && !ext_any) |-> cpu_ready_o);

  // R4
  ext_min_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_any && cpu_ready_o) |-> ({1'b0, ws_cfg_i} <= wait_cnt_q));

  // R4
  ext_no_overstall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_any && !cpu_ready_o && ext_ready_i) |-> (wait_cnt_q < {1'b0, ws_cfg_i}));

  // R5
  ext_ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_any && cpu_ready_o) |-> ext_ready_i);

  // R6
  ram_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_rd_i && cpu_addr_i >= RAM_LO && cpu_addr_i < RAM_HI && !ext_any)
      |-> (ram_we_o && cpu_ready_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (cpu_ready_o && !ext_any && !ram_we_o));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ext_any));

  // R9
  always_comb begin
    if (rst_ni == 1'b0) begin
      reset_quiet_chk: assert (!ext_rd_o && !ext_wr_o);
    end
  end
endmodule

bind prog_mem_decoder prog_mem_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .ROM_AW  (ROM_AW),
  .RAM_AW  (RAM_AW),
  .RAM_BASE(RAM_BASE),
  .WS_W    (WS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_addr_i (cpu_addr_i),
  .cpu_rd_i   (cpu_rd_i),
  .cpu_wr_i   (cpu_wr_i),
  .cpu_ready_o(cpu_ready_o),
  .ws_cfg_i   (ws_cfg_i),
  .ram_we_o   (ram_we_o),
  .ext_rd_o   (ext_rd_o),
  .ext_wr_o   (ext_wr_o),
  .ext_ready_i(ext_ready_i)
);

// File: tb/prog_mem_decoder_tb.sv
`timescale 1ns/1ps
module prog_mem_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [23:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata_o;
  logic        cpu_ready_o;
  logic [2:0]  ws_cfg;
  logic [9:0]  rom_addr_o;
  logic [7:0]  rom_rdata;
  logic [11:0] ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic        ram_we_o;
  logic [7:0]  ram_rdata;
  logic [23:0] ext_addr_o;
  logic [7:0]  ext_wdata_o;
  logic        ext_rd_o, ext_wr_o;
  logic [7:0]  ext_rdata;
  logic        ext_ready;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  prog_mem_decoder u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cpu_addr_i (cpu_addr),
    .cpu_rd_i   (cpu_rd),
    .cpu_wr_i   (cpu_wr),
    .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata_o),
    .cpu_ready_o(cpu_ready_o),
    .ws_cfg_i   (ws_cfg),
    .rom_addr_o (rom_addr_o),
    .rom_rdata_i(rom_rdata),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .ram_we_o   (ram_we_o),
    .ram_rdata_i(ram_rdata),
    .ext_addr_o (ext_addr_o),
    .ext_wdata_o(ext_wdata_o),
    .ext_rd_o   (ext_rd_o),
    .ext_wr_o   (ext_wr_o),
    .ext_rdata_i(ext_rdata),
    .ext_ready_i(ext_ready)
  );

  // behavioural memories
  function automatic logic [7:0] rom_f(input logic [9:0] a);
    return ~a[7:0] + {6'd0, a[9:8]};
  endfunction
  function automatic logic [7:0] ram_init_f(input logic [11:0] a);
    return a[7:0] + {4'd0, a[11:8]} + 8'h11;
  endfunction
  function automatic logic [7:0] ext_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
  endfunction

  logic [7:0]  ram_mem [0:4095];
  logic        ram_vld [0:4095];
  logic [23:0] ext_last_a;
  logic [7:0]  ext_last_d;
  int          ext_wr_cnt = 0;

  assign rom_rdata = rom_f(rom_addr_o);
  assign ram_rdata = (ram_vld[ram_addr_o] === 1'b1) ? ram_mem[ram_addr_o] : ram_init_f(ram_addr_o);
  assign ext_rdata = ext_f(ext_addr_o);

  always @(posedge clk) begin
    if (ram_we_o) begin
      ram_mem[ram_addr_o] <= ram_wdata_o;
      ram_vld[ram_addr_o] <= 1'b1;
    end
    if (ext_wr_o && cpu_ready_o) begin
      ext_last_a <= ext_addr_o;
      ext_last_d <= ext_wdata_o;
      ext_wr_cnt <= ext_wr_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one access; k = cycles with ext_ready held low from the start
  task automatic access(input logic [23:0] a, input logic wr, input logic [7:0] wd,
                        input int k, output int waits, output logic [7:0] rd,
                        output logic saw_ramwe, output logic saw_extwr,
                        output logic [23:0] ea);
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_rd = !wr; cpu_wdata = wd;
    waits = 0; saw_ramwe = 1'b0; saw_extwr = 1'b0;
    while (1) begin
      ext_ready = (waits >= k);
      #2;
      saw_ramwe = saw_ramwe | ram_we_o;
      saw_extwr = saw_extwr | ext_wr_o;
      if (cpu_ready_o) break;
      waits++;
      if (waits > 40) break;
      @(negedge clk);
    end
    rd = cpu_rdata_o;
    ea = ext_addr_o;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; ext_ready = 1'b1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_ni = 1'b0;
    cpu_addr = 24'h000400; cpu_rd = 1'b1;
    #2;
    chk(!ext_rd_o && !ext_wr_o, "R9", "strobes in reset", {ext_rd_o, ext_wr_o}, 0);
    @(negedge clk);
    cpu_rd = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk); #2;
    chk(cpu_ready_o && !ext_rd_o && !ext_wr_o && !ram_we_o, "R10", "idle outputs",
        {cpu_ready_o, ext_rd_o, ext_wr_o, ram_we_o}, 4'b1000);
  endtask

  task automatic t_rom_read();
    logic [23:0] addrs [3] = '{24'h000000, 24'h0003FF, 24'h000155};
    foreach (addrs[i]) begin
      int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
      access(addrs[i], 1'b0, 8'h00, 0, w, d, sr, sw, ea);
      chk(w == 0, "R1", "rom waits", w, 0);
      chk(d == rom_f(addrs[i][9:0]), "R1", "rom data", d, rom_f(addrs[i][9:0]));
    end
  endtask

  task automatic t_ram_read();
    logic [23:0] addrs [3] = '{24'h00F000, 24'h00FFFF, 24'h00F123};
    foreach (addrs[i]) begin
      int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
      access(addrs[i], 1'b0, 8'h00, 0, w, d, sr, sw, ea);
      chk(w == 0, "R2", "ram waits", w, 0);
      chk(d == ram_init_f(addrs[i][11:0]), "R2", "ram data", d, ram_init_f(addrs[i][11:0]));
    end
  endtask

  task automatic t_ext_read();
    logic [23:0] addrs [4] = '{24'h000400, 24'h00EFFF, 24'h010000, 24'hFFFFFF};
    logic [2:0]  wss   [4] = '{3'd0, 3'd2, 3'd5, 3'd7};
    foreach (addrs[i]) begin
      int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
      ws_cfg = wss[i];
      access(addrs[i], 1'b0, 8'h00, 0, w, d, sr, sw, ea);
      chk(w == int'(wss[i]), "R4", "ext waits", w, int'(wss[i]));
      chk(ea == addrs[i], "R3", "ext address", ea, addrs[i]);
      chk(d == ext_f(addrs[i]), "R3", "ext data", d, ext_f(addrs[i]));
    end
  endtask

  task automatic t_ext_stretch();
    int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
    ws_cfg = 3'd2;
    access(24'h123456, 1'b0, 8'h00, 5, w, d, sr, sw, ea);
    chk(w == 5, "R5", "stretched waits", w, 5);
    chk(d == ext_f(24'h123456), "R5", "stretched data", d, ext_f(24'h123456));
    ws_cfg = 3'd4;
    access(24'h000800, 1'b0, 8'h00, 1, w, d, sr, sw, ea);
    chk(w == 4, "R5", "short ext_ready low", w, 4);
  endtask

  task automatic t_ram_write();
    int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
    access(24'h00F010, 1'b1, 8'hA5, 0, w, d, sr, sw, ea);
    chk(w == 0 && sr && !sw, "R6", "ram write strobe/waits", {w[7:0], sr, sw}, 10'b10);
    access(24'h00F010, 1'b0, 8'h00, 0, w, d, sr, sw, ea);
    chk(d == 8'hA5, "R6", "ram readback", d, 8'hA5);
  endtask

  task automatic t_rom_write();
    int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
    int wc0;
    wc0 = ext_wr_cnt;
    access(24'h000010, 1'b1, 8'hEE, 0, w, d, sr, sw, ea);
    chk(w == 0 && !sr && !sw, "R7", "rom write quiet", {w[7:0], sr, sw}, 0);
    access(24'h000010, 1'b0, 8'h00, 0, w, d, sr, sw, ea);
    chk(d == rom_f(10'h010), "R7", "rom unchanged", d, rom_f(10'h010));
    access(24'h00F010, 1'b0, 8'h00, 0, w, d, sr, sw, ea);
    chk(d == 8'hA5, "R7", "aliased ram byte unchanged", d, 8'hA5);
    chk(ext_wr_cnt == wc0, "R7", "no ext write", ext_wr_cnt, wc0);
  endtask

  task automatic t_ext_write();
    int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
    ws_cfg = 3'd3;
    access(24'h020000, 1'b1, 8'h3C, 0, w, d, sr, sw, ea);
    chk(w == 3, "R8", "ext write waits", w, 3);
    chk(sw && !sr, "R11", "ext write strobe only", {sr, sw}, 2'b01);
    chk(ext_last_a == 24'h020000, "R8", "ext write addr", ext_last_a, 24'h020000);
    chk(ext_last_d == 8'h3C, "R8", "ext write data", ext_last_d, 8'h3C);
  endtask

  task automatic t_reset_mid();
    int w; logic [7:0] d; logic sr, sw; logic [23:0] ea;
    ws_cfg = 3'd5;
    @(negedge clk);
    cpu_addr = 24'h004000; cpu_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    chk(!ext_rd_o, "R9", "strobe dropped by reset", ext_rd_o, 0);
    @(negedge clk);
    cpu_rd = 1'b0;
    rst_ni = 1'b1;
    access(24'h004000, 1'b0, 8'h00, 0, w, d, sr, sw, ea);
    chk(w == 5, "R9", "full wait after reset", w, 5);
  endtask

  initial begin
    rst_ni = 1'b0;
    cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    ws_cfg = 3'd2; ext_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_rom_read();
    t_ram_read();
    t_ext_read();
    t_ext_stretch();
    t_ram_write();
    t_rom_write();
    t_ext_write();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule